// File: doc/BRIEF.md
# Reset Cause and Startup Sequencer

This block is the reset controller of a small 8-bit microcontroller core. Four reset sources feed it. The first is power-on, which is the block's own asynchronous reset. The second is an external active-low clear pin, passed through a two-flop synchronizer and a glitch filter. The third is a watchdog time-out strobe, and the fourth is a power-edge-detect strobe. The block merges them into one internal core reset. After the last reset event, it keeps the core in reset for an oscillator start-up interval. That interval is counted in periods of a free-running tick, and a two-bit option selects one of four lengths.

Two status flags tell software why the core restarted: a time-out flag and a power-loss flag. They are written by reset events, by the sleep command and by the clear-watchdog command, and the block also knows whether the core was asleep when the event arrived. The block tracks sleep state. It removes the core clock enable while the core sleeps, and any reset event wakes the core. While reset is held, it forces every port pin to input mode. It also presents the restart address, which is the last word of program memory.

Top module: `rst_cause_seq`

## Requirements
- R1: While `por_n` is low, and in the cycle after it rises, `core_rst` is 1, `flag_to` is 1, `flag_pd` is 1, `asleep` is 0 and `core_clk_en` is 1.
- R2: A reset event in cycle k sets `core_rst` from the next edge and restarts the hold count. `core_rst` falls at the edge where the HOLD_Nth `tick` pulse after the event is sampled. The value of `ost_sel` (0 to 3) picks HOLD_0 to HOLD_3.
- R3: A low pulse on `ext_clr_n` is ignored if it is seen low for fewer than FILT_CYC consecutive cycles after the two synchronizer flops. It changes no output.
- R4: A low level on `ext_clr_n` that lasts FILT_CYC synchronized cycles is a reset event. `core_rst` stays 1 while the level stays low, and the hold count restarts when the pin returns high.
- R5: An accepted external clear leaves both flags unchanged when the core is awake. When the core is asleep it sets `flag_to`=1 and `flag_pd`=0.
- R6: A `wdt_evt` strobe sets `flag_to`=0. It sets `flag_pd`=1 when the core is awake and `flag_pd`=0 when the core is asleep.
- R7: A `ped_evt` strobe sets both flags to 1 and starts a reset.
- R8: A `sleep_cmd` strobe while the core is awake and out of reset sets `flag_to`=1, `flag_pd`=0 and `asleep`=1, and drops `core_clk_en`. While `core_rst` is 1 the strobe is ignored.
- R9: A `clrwdt_cmd` strobe while the core is awake and out of reset sets both flags to 1. While `core_rst` is 1 the strobe is ignored.
- R10: Every reset event clears `asleep` and restores `core_clk_en`.
- R11: When several sources fire in the same cycle, only the winner writes the flags. The order of precedence is power edge, then watchdog, then external clear, then sleep, then clear-watchdog.
- R12: `dir_force_in` equals `core_rst`, and `rst_vec` equals all ones over PC_W bits (0x3FF for PC_W=10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_clr_n | input | 1 | Raw external clear pin, active low, asynchronous |
| wdt_evt | input | 1 | Watchdog time-out strobe |
| ped_evt | input | 1 | Power-edge-detect strobe |
| tick | input | 1 | Free-running start-up time base pulse |
| ost_sel | input | 2 | Start-up interval option |
| sleep_cmd | input | 1 | Sleep command strobe from the core |
| clrwdt_cmd | input | 1 | Clear-watchdog command strobe from the core |
| core_rst | output | 1 | Internal core reset, active high |
| core_clk_en | output | 1 | Core clock enable, low while asleep |
| asleep | output | 1 | Sleep state |
| flag_to | output | 1 | Time-out status flag |
| flag_pd | output | 1 | Power-loss status flag |
| dir_force_in | output | 1 | Forces all port direction bits to input |
| rst_vec | output | PC_W | Program counter restart address |

## Verification
The bench sends external-clear pulses that are one cycle shorter than the filter window and pulses that just reach it. A filter that is off by one would either reset the core on a glitch or ignore a real clear. Each event is raised once while the core is awake and once while it sleeps. A design that ignored sleep state would leave the wrong flag pair, and the reset cause could then not be told apart. Several sources are made to collide in the same cycle, and commands are sent while reset is held, to expose a wrong precedence order or a command leaking through during reset. The bench steps through all four interval options to catch a limit that is swapped or short by one tick.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_XCLR = 2'd1,
    EV_WDOG = 2'd2,
    EV_PEDG = 2'd3
  } rst_src_e;
endpackage

// File: rtl/xclr_filter.sv
module xclr_filter #(
  parameter int FILT_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic filt_low,
  output logic filt_low_nx,
  output logic accept
);
  localparam int LW = $clog2(FILT_CYC + 1);

  logic          s1_q, s2_q;
  logic [LW-1:0] run_q, run_d;
  logic          low_q, low_d;

  always_comb begin
    if (s2_q) begin
      run_d = '0;
    end else if (run_q != LW'(FILT_CYC)) begin
      run_d = run_q + LW'(1);
    end else begin
      run_d = run_q;
    end
    low_d = !s2_q && (run_d == LW'(FILT_CYC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      run_q <= '0;
      low_q <= 1'b0;
    end else begin
      s1_q  <= pin_n;
      s2_q  <= s1_q;
      run_q <= run_d;
      low_q <= low_d;
    end
  end

  assign filt_low    = low_q;
  assign filt_low_nx = low_d;
  assign accept      = low_d && !low_q;

  // R3: the filtered level only rises after the synchronized pin was low
  p_glitch_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_q) |-> $past(!s2_q));
  // R4: a synchronized high releases the filtered level at once
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s2_q |=> !low_q);
endmodule

// File: rtl/ost_timer.sv
module ost_timer #(
  parameter int HOLD_0 = 150,
  parameter int HOLD_1 = 20000,
  parameter int HOLD_2 = 40000,
  parameter int HOLD_3 = 80000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       busy
);
  localparam int HMAX01 = (HOLD_0 > HOLD_1) ? HOLD_0 : HOLD_1;
  localparam int HMAX23 = (HOLD_2 > HOLD_3) ? HOLD_2 : HOLD_3;
  localparam int HMAX   = (HMAX01 > HMAX23) ? HMAX01 : HMAX23;
  localparam int CW     = $clog2(HMAX + 1);

  logic [CW-1:0] lim;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    unique case (sel)
      2'd0:    lim = CW'(HOLD_0);
      2'd1:    lim = CW'(HOLD_1);
      2'd2:    lim = CW'(HOLD_2);
      default: lim = CW'(HOLD_3);
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q && tick) begin
      if (cnt_q == lim - CW'(1)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  // R2: reset is only released on a sampled tick
  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(tick));
  // R2: any start holds reset in the next cycle
  p_start_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
endmodule

// File: rtl/cause_flags.sv
module cause_flags
  import rst_cause_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ped_evt,
  input  logic wdt_evt,
  input  logic xclr_evt,
  input  logic sleep_cmd,
  input  logic clrwdt_cmd,
  input  logic in_rst,
  output logic flag_to,
  output logic flag_pd,
  output logic asleep
);
  rst_src_e src;
  logic     to_q, to_d, pd_q, pd_d, slp_q, slp_d;
  logic     cmd_ok;

  always_comb begin
    if (ped_evt)       src = EV_PEDG;
    else if (wdt_evt)  src = EV_WDOG;
    else if (xclr_evt) src = EV_XCLR;
    else               src = EV_NONE;
  end

  assign cmd_ok = !in_rst && !slp_q;

  always_comb begin
    to_d  = to_q;
    pd_d  = pd_q;
    slp_d = slp_q;
    unique case (src)
      EV_PEDG: begin
        to_d = 1'b1;
        pd_d = 1'b1;
      end
      EV_WDOG: begin
        to_d = 1'b0;
        pd_d = !slp_q;
      end
      EV_XCLR: begin
        if (slp_q) begin
          to_d = 1'b1;
          pd_d = 1'b0;
        end
      end
      default: begin
        if (cmd_ok && sleep_cmd) begin
          to_d  = 1'b1;
          pd_d  = 1'b0;
          slp_d = 1'b1;
        end else if (cmd_ok && clrwdt_cmd) begin
          to_d = 1'b1;
          pd_d = 1'b1;
        end
      end
    endcase
    if (src != EV_NONE) slp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q  <= 1'b1;
      pd_q  <= 1'b1;
      slp_q <= 1'b0;
    end else begin
      to_q  <= to_d;
      pd_q  <= pd_d;
      slp_q <= slp_d;
    end
  end

  assign flag_to = to_q;
  assign flag_pd = pd_q;
  assign asleep  = slp_q;

  // R6: a watchdog event that wins clears the time-out flag
  p_wdt_to_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_evt && !ped_evt) |=> !to_q);
  // R7: a power-edge event sets both flags
  p_ped_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ped_evt |=> (to_q && pd_q));
  // R10: any reset event wakes the core
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ped_evt || wdt_evt || xclr_evt) |=> !slp_q);
  // R8: sleep command is ignored while reset is held
  p_sleep_in_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rst && !slp_q) |=> !slp_q);
endmodule

// File: rtl/rst_cause_seq.sv
module rst_cause_seq #(
  parameter int FILT_CYC = 200,
  parameter int HOLD_0   = 150,
  parameter int HOLD_1   = 20000,
  parameter int HOLD_2   = 40000,
  parameter int HOLD_3   = 80000,
  parameter int PC_W     = 10
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            ext_clr_n,
  input  logic            wdt_evt,
  input  logic            ped_evt,
  input  logic            tick,
  input  logic [1:0]      ost_sel,
  input  logic            sleep_cmd,
  input  logic            clrwdt_cmd,
  output logic            core_rst,
  output logic            core_clk_en,
  output logic            asleep,
  output logic            flag_to,
  output logic            flag_pd,
  output logic            dir_force_in,
  output logic [PC_W-1:0] rst_vec
);
  logic xlow, xlow_nx, xacc, busy, start, slp;

  xclr_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(por_n), .pin_n(ext_clr_n),
    .filt_low(xlow), .filt_low_nx(xlow_nx), .accept(xacc)
  );

  assign start = ped_evt || wdt_evt || xlow_nx;

  ost_timer #(.HOLD_0(HOLD_0), .HOLD_1(HOLD_1), .HOLD_2(HOLD_2),
              .HOLD_3(HOLD_3)) u_ost (
    .clk(clk), .rst_n(por_n), .start(start), .tick(tick),
    .sel(ost_sel), .busy(busy)
  );

  cause_flags u_flags (
    .clk(clk), .rst_n(por_n), .ped_evt(ped_evt), .wdt_evt(wdt_evt),
    .xclr_evt(xacc), .sleep_cmd(sleep_cmd), .clrwdt_cmd(clrwdt_cmd),
    .in_rst(busy), .flag_to(flag_to), .flag_pd(flag_pd), .asleep(slp)
  );

  assign core_rst     = busy;
  assign asleep       = slp;
  assign core_clk_en  = !slp;
  assign dir_force_in = busy;
  assign rst_vec      = '1;

  // R4: while the filtered clear level is low the core stays in reset
  p_hold_low_r4: assert property (@(posedge clk) disable iff (!por_n)
    xlow |-> core_rst);
  // R8: clock enable stays low while the core sleeps
  p_clk_gate_r8: assert property (@(posedge clk) disable iff (!por_n)
    slp |-> !core_clk_en);
endmodule

// File: tb/tb_rst_cause_seq.sv
`timescale 1ns/1ps
module tb_rst_cause_seq;
  localparam int FILT = 4;
  localparam int H0 = 2, H1 = 5, H2 = 7, H3 = 10;
  localparam int PCW = 10;

  logic clk = 1'b0;
  logic por_n, ext_clr_n, wdt_evt, ped_evt, tick, sleep_cmd, clrwdt_cmd;
  logic [1:0] ost_sel;
  logic core_rst, core_clk_en, asleep, flag_to, flag_pd, dir_force_in;
  logic [PCW-1:0] rst_vec;

  always #2.5 clk = ~clk;

  rst_cause_seq #(.FILT_CYC(FILT), .HOLD_0(H0), .HOLD_1(H1), .HOLD_2(H2),
                  .HOLD_3(H3), .PC_W(PCW)) dut (
    .clk(clk), .por_n(por_n), .ext_clr_n(ext_clr_n), .wdt_evt(wdt_evt),
    .ped_evt(ped_evt), .tick(tick), .ost_sel(ost_sel),
    .sleep_cmd(sleep_cmd), .clrwdt_cmd(clrwdt_cmd), .core_rst(core_rst),
    .core_clk_en(core_clk_en), .asleep(asleep), .flag_to(flag_to),
    .flag_pd(flag_pd), .dir_force_in(dir_force_in), .rst_vec(rst_vec)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  string req = "R1";

  // behavioural reference state
  bit m_s1, m_s2, m_flow, m_busy, m_to, m_pd, m_slp;
  int m_low, m_cnt;

  function automatic int hold_of(logic [1:0] s);
    case (s)
      2'd0: return H0;
      2'd1: return H1;
      2'd2: return H2;
      default: return H3;
    endcase
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_s1 = 1; m_s2 = 1; m_low = 0; m_flow = 0;
      m_busy = 1; m_cnt = 0; m_to = 1; m_pd = 1; m_slp = 0;
    end else begin
      int nlow; bit nflow, ev_x, ok, ev_any;
      nlow  = m_s2 ? 0 : ((m_low < FILT) ? m_low + 1 : m_low);
      nflow = !m_s2 && (nlow >= FILT);
      ev_x  = nflow && !m_flow;
      ok    = !m_busy && !m_slp;
      ev_any = ped_evt || wdt_evt || ev_x;
      if (ped_evt) begin m_to = 1; m_pd = 1; end
      else if (wdt_evt) begin m_to = 0; m_pd = !m_slp; end
      else if (ev_x) begin if (m_slp) begin m_to = 1; m_pd = 0; end end
      else if (ok && sleep_cmd) begin m_to = 1; m_pd = 0; m_slp = 1; end
      else if (ok && clrwdt_cmd) begin m_to = 1; m_pd = 1; end
      if (ev_any) m_slp = 0;
      if (ped_evt || wdt_evt || nflow) begin m_busy = 1; m_cnt = 0; end
      else if (m_busy && tick) begin
        if (m_cnt == hold_of(ost_sel) - 1) begin m_busy = 0; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      m_s2 = m_s1; m_s1 = ext_clr_n; m_low = nlow; m_flow = nflow;
    end
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(req, "core_rst", core_rst, m_busy);
      chk(req, "flag_to", flag_to, m_to);
      chk(req, "flag_pd", flag_pd, m_pd);
      chk(req, "asleep", asleep, m_slp);
      chk("R8", "core_clk_en", core_clk_en, !m_slp);
      chk("R12", "dir_force_in", dir_force_in, m_busy);
    end
  end

  // tick every third cycle
  initial begin
    tick = 0;
    forever begin
      repeat (2) @(negedge clk);
      tick = 1;
      @(negedge clk);
      tick = 0;
    end
  end

  task automatic pulse_wdt();  @(negedge clk) wdt_evt = 1;    @(negedge clk) wdt_evt = 0;    endtask
  task automatic pulse_ped();  @(negedge clk) ped_evt = 1;    @(negedge clk) ped_evt = 0;    endtask
  task automatic pulse_slp();  @(negedge clk) sleep_cmd = 1;  @(negedge clk) sleep_cmd = 0;  endtask
  task automatic pulse_cwd();  @(negedge clk) clrwdt_cmd = 1; @(negedge clk) clrwdt_cmd = 0; endtask
  task automatic low_for(input int n);
    @(negedge clk) ext_clr_n = 0;
    repeat (n) @(negedge clk);
    ext_clr_n = 1;
  endtask
  task automatic wait_rel();
    int k = 0;
    while (core_rst && k < 500) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    por_n = 0; ext_clr_n = 1; wdt_evt = 0; ped_evt = 0;
    sleep_cmd = 0; clrwdt_cmd = 0; ost_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1", "core_rst in reset", core_rst, 1);
    por_n = 1;
    @(negedge clk);
    chk("R1", "flag_to after power-on", flag_to, 1);
    chk("R1", "flag_pd after power-on", flag_pd, 1);
    chk("R12", "rst_vec", rst_vec, 10'h3FF);
    req = "R2"; wait_rel();
    chk("R2", "released with option 0", core_rst, 0);

    // R2, R6: all interval options, watchdog while awake
    for (int s = 1; s < 4; s++) begin
      ost_sel = 2'(s);
      pulse_wdt();
      chk("R6", "to after awake wdt", flag_to, 0);
      chk("R6", "pd after awake wdt", flag_pd, 1);
      wait_rel();
    end
    ost_sel = 2'd0;

    // R9: clear-watchdog restores both flags
    req = "R9"; pulse_cwd();
    chk("R9", "to after clrwdt", flag_to, 1);
    chk("R9", "pd after clrwdt", flag_pd, 1);

    // R3: glitch one cycle short of the window
    req = "R3"; pulse_wdt(); wait_rel(); pulse_cwd();
    low_for(FILT - 1);
    repeat (8) @(negedge clk);
    chk("R3", "core_rst after glitch", core_rst, 0);

    // R4, R5: full-length clear while awake keeps flags
    req = "R4"; pulse_wdt(); wait_rel();
    low_for(FILT + 6);
    chk("R4", "core_rst while clear low", core_rst, 1);
    chk("R5", "to unchanged awake clear", flag_to, 0);
    chk("R5", "pd unchanged awake clear", flag_pd, 1);
    wait_rel();

    // R8: sleep command, then R5/R10: clear while asleep
    req = "R8"; pulse_slp();
    chk("R8", "asleep", asleep, 1);
    chk("R8", "clk_en in sleep", core_clk_en, 0);
    chk("R8", "to after sleep", flag_to, 1);
    chk("R8", "pd after sleep", flag_pd, 0);
    req = "R5"; low_for(FILT + 3);
    chk("R10", "woken by clear", asleep, 0);
    chk("R5", "to clear in sleep", flag_to, 1);
    chk("R5", "pd clear in sleep", flag_pd, 0);
    wait_rel();

    // R6: watchdog during sleep
    req = "R6"; pulse_slp(); pulse_wdt();
    chk("R6", "to wdt in sleep", flag_to, 0);
    chk("R6", "pd wdt in sleep", flag_pd, 0);
    chk("R10", "woken by wdt", asleep, 0);
    // R8, R9: commands ignored during reset
    pulse_slp();
    chk("R8", "sleep ignored in reset", asleep, 0);
    pulse_cwd();
    chk("R9", "clrwdt ignored in reset to", flag_to, 0);
    wait_rel();

    // R7: power edge
    req = "R7"; pulse_ped();
    chk("R7", "to after ped", flag_to, 1);
    chk("R7", "pd after ped", flag_pd, 1);
    chk("R7", "reset from ped", core_rst, 1);
    wait_rel();

    // R11: collisions
    req = "R11";
    @(negedge clk) begin wdt_evt = 1; ped_evt = 1; end
    @(negedge clk) begin wdt_evt = 0; ped_evt = 0; end
    chk("R11", "ped beats wdt to", flag_to, 1);
    chk("R11", "ped beats wdt pd", flag_pd, 1);
    wait_rel();
    @(negedge clk) begin wdt_evt = 1; sleep_cmd = 1; end
    @(negedge clk) begin wdt_evt = 0; sleep_cmd = 0; end
    chk("R11", "wdt beats sleep asleep", asleep, 0);
    chk("R11", "wdt beats sleep to", flag_to, 0);
    wait_rel();
    @(negedge clk) begin sleep_cmd = 1; clrwdt_cmd = 1; end
    @(negedge clk) begin sleep_cmd = 0; clrwdt_cmd = 0; end
    chk("R11", "sleep beats clrwdt pd", flag_pd, 0);
    chk("R11", "sleep beats clrwdt asleep", asleep, 1);
    pulse_ped(); wait_rel();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule